// File: doc/BRIEF.md
# Bit-Serial Add-Compare-Select Element

This block performs the add-compare-select step of a trellis decoder for a single state, one bit per clock. Two predecessor state metrics and the two branch metrics that lead from them arrive as serial streams, least significant bit first, framed by a one-cycle word-start pulse on bit 0. The block forms both candidate metrics with single-bit adders that each keep one carry flip-flop. A third single-bit adder subtracts the lower candidate from the upper one as the bits arrive. The sign of that modular difference, known on the last bit, selects the survivor.

The winning candidate is written into a local metric register. The decision bit is published for the traceback logic. During the following word frame the stored metric is sent back out serially, in the same LSB-first framing, so that it can feed the next trellis stage. Metrics are unsigned words of `W` bits that wrap modulo 2^W. Normalization across states is left to the surrounding decoder.

Top module: `acs_serial`

## Requirements
- R1: While reset is low and before any word frame, `pick_valid_o` and `pick_lo_o` are 0, and `metric_o` is 0 outside a frame. The stored metric starts at `RESET_METRIC`, which defaults to 0.
- R2: Each candidate equals (predecessor metric + branch metric) mod 2^W. The upper candidate uses `metric_up_i`/`branch_up_i` and the lower one uses `metric_lo_i`/`branch_lo_i`. The bit on a cycle where `word_start_i` is high is bit 0, and the carry into bit 0 is 0.
- R3: The decision is 1 exactly when bit W-1 of (upper candidate − lower candidate) mod 2^W is 1. The stored metric becomes the lower candidate when the decision is 1 and the upper candidate when it is 0.
- R4: Equal candidates give decision 0, so the upper candidate is kept.
- R5: `pick_valid_o` is high for exactly one cycle, the cycle after bit W-1 of a frame. `pick_lo_o` then shows the new decision and holds it until the next decision.
- R6: During a frame, `metric_o` carries bit k of the stored metric in the cycle of input bit k. The stored metric is the one present before that frame's own decision.
- R7: The stored metric changes only at the end of a complete frame. Across idle gaps it is held, and it is repeated in every later frame until it is replaced.
- R8: A `word_start_i` pulse inside a frame abandons that frame: no decision is produced, the stored metric is unchanged, and a new frame starts at bit 0.
- R9: Input bits on cycles outside a frame (no start pulse, no frame in progress) have no effect. `metric_o` is 0 on those cycles.
- R10: Frames may follow each other with no idle cycle in between. The next start pulse may arrive in the cycle right after bit W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_start_i | input | 1 | High on the cycle of bit 0 of a frame |
| metric_up_i | input | 1 | Serial metric of the upper predecessor state |
| metric_lo_i | input | 1 | Serial metric of the lower predecessor state |
| branch_up_i | input | 1 | Serial branch metric for the upper transition |
| branch_lo_i | input | 1 | Serial branch metric for the lower transition |
| metric_o | output | 1 | Serial stored metric of this state, LSB first, within a frame |
| pick_lo_o | output | 1 | Survivor decision: 1 selects the lower transition |
| pick_valid_o | output | 1 | One-cycle pulse when a new decision is available |

## Verification
The hardest condition to reach from the ports is the compare across a wrap of the modular difference. Here the candidate sums overflow and land near half the range apart, so the sign bit of the serial subtraction and a naive magnitude compare give different answers. The stimulus adds directed frames with sums that overflow and pairs that straddle the half-range point to the seeded random frames. Two further cases come from framing: a start pulse that cuts a frame short, and back-to-back frames in which the decision pulse and the next bit 0 share a cycle. The random schedule produces both, with short gaps carrying garbage input bits between frames.

// File: rtl/acs_serial_pkg.sv
package acs_serial_pkg;

  typedef enum logic {
    PICK_UPPER = 1'b0,
    PICK_LOWER = 1'b1
  } pick_e;

  function automatic logic fa_sum(logic a, logic b, logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/acs_frame_ctrl.sv
module acs_frame_ctrl #(
  parameter int W  = 8,
  localparam int CW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          word_start_i,
  output logic          active_o,
  output logic          last_o,
  output logic [CW-1:0] pos_o
);

  localparam logic [CW-1:0] LastPos = CW'(W - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign active_o = word_start_i | busy_q;
  assign pos_o    = word_start_i ? '0 : cnt_q;
  assign last_o   = active_o && (pos_o == LastPos);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (active_o) begin
      if (last_o) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        busy_q <= 1'b1;
        cnt_q  <= pos_o + CW'(1);
      end
    end
  end

  // R8: an open frame always sits strictly between bit 0 and bit W-1
  assert_frame_pos_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0) && (cnt_q <= LastPos));

endmodule

// File: rtl/acs_bit_adder.sv
module acs_bit_adder
  import acs_serial_pkg::*;
#(
  parameter logic CARRY_INIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  input  logic a_i,
  input  logic b_i,
  output logic sum_o
);

  logic carry_q;
  logic carry_in;

  assign carry_in = clear_i ? CARRY_INIT : carry_q;
  assign sum_o    = fa_sum(a_i, b_i, carry_in);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   carry_q <= CARRY_INIT;
    else if (en_i) carry_q <= fa_carry(a_i, b_i, carry_in);
  end

endmodule

// File: rtl/acs_word_shift.sv
module acs_word_shift #(
  parameter int D = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [D-1:0] word_o
);

  logic [D-1:0] hist_q;

  generate
    if (D == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   hist_q <= '0;
        else if (en_i) hist_q <= bit_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   hist_q <= '0;
        else if (en_i) hist_q <= {bit_i, hist_q[D-1:1]};
      end
    end
  endgenerate

  assign word_o = hist_q;

endmodule

// File: rtl/acs_serial.sv
module acs_serial
  import acs_serial_pkg::*;
#(
  parameter int             W            = 8,
  parameter logic [W-1:0]   RESET_METRIC = '0,
  localparam int            CW           = (W > 1) ? $clog2(W) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic word_start_i,
  input  logic metric_up_i,
  input  logic metric_lo_i,
  input  logic branch_up_i,
  input  logic branch_lo_i,
  output logic metric_o,
  output logic pick_lo_o,
  output logic pick_valid_o
);

  localparam int NLANE = 2;

  logic          active;
  logic          last;
  logic [CW-1:0] pos;

  acs_frame_ctrl #(.W(W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_start_i(word_start_i),
    .active_o    (active),
    .last_o      (last),
    .pos_o       (pos)
  );

  logic [NLANE-1:0]            pm_bit;
  logic [NLANE-1:0]            bm_bit;
  logic [NLANE-1:0]            cand_bit;
  logic [NLANE-1:0][W-2:0]     cand_hist;
  logic [NLANE-1:0][W-1:0]     cand_word;

  assign pm_bit = {metric_lo_i, metric_up_i};
  assign bm_bit = {branch_lo_i, branch_up_i};

  // lane 0 = upper transition, lane 1 = lower transition
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    acs_bit_adder #(.CARRY_INIT(1'b0)) i_add (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(word_start_i),
      .en_i   (active),
      .a_i    (pm_bit[l]),
      .b_i    (bm_bit[l]),
      .sum_o  (cand_bit[l])
    );

    acs_word_shift #(.D(W - 1)) i_hist (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (active),
      .bit_i (cand_bit[l]),
      .word_o(cand_hist[l])
    );

    // full word is complete on the last bit cycle
    assign cand_word[l] = {cand_bit[l], cand_hist[l]};
  end

  // upper - lower: add inverted lower with carry preset to 1
  logic diff_bit;

  acs_bit_adder #(.CARRY_INIT(1'b1)) i_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(word_start_i),
    .en_i   (active),
    .a_i    (cand_bit[0]),
    .b_i    (~cand_bit[1]),
    .sum_o  (diff_bit)
  );

  pick_e        pick_now;
  logic [W-1:0] state_q;
  pick_e        pick_q;
  logic         valid_q;

  assign pick_now = diff_bit ? PICK_LOWER : PICK_UPPER;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RESET_METRIC;
      pick_q  <= PICK_UPPER;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last;
      if (last) begin
        pick_q  <= pick_now;
        state_q <= (pick_now == PICK_LOWER) ? cand_word[1] : cand_word[0];
      end
    end
  end

  assign metric_o     = active ? state_q[pos] : 1'b0;
  assign pick_lo_o    = (pick_q == PICK_LOWER);
  assign pick_valid_o = valid_q;

  logic [W-1:0] word_diff;
  assign word_diff = cand_word[0] - cand_word[1];

  assert_serial_compare_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |-> (diff_bit == word_diff[W-1]));

  assert_tie_upper_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last && (cand_word[0] == cand_word[1])) |-> !diff_bit);

  assert_pick_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid_o |=> !pick_valid_o);

  assert_pick_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(pick_lo_o));

  assert_store_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(state_q));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !metric_o);

endmodule

// File: tb/test_acs_serial.sv
`timescale 1ns/1ps
module test_acs_serial;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic word_start_i = 1'b0;
  logic metric_up_i = 1'b0, metric_lo_i = 1'b0, branch_up_i = 1'b0, branch_lo_i = 1'b0;
  logic metric_o, pick_lo_o, pick_valid_o;

  always #2.5 clk = ~clk;

  acs_serial #(.W(W)) i_acs_serial (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .word_start_i(word_start_i),
    .metric_up_i (metric_up_i),
    .metric_lo_i (metric_lo_i),
    .branch_up_i (branch_up_i),
    .branch_lo_i (branch_lo_i),
    .metric_o    (metric_o),
    .pick_lo_o   (pick_lo_o),
    .pick_valid_o(pick_valid_o)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string phase  = "reset";

  // reference model state
  logic [W-1:0] acc_pu, acc_pl, acc_bu, acc_bl;
  logic [W-1:0] exp_store = '0;
  logic         exp_pick  = 1'b0;
  bit           pend      = 1'b0;
  bit           mbusy     = 1'b0;
  int           mcnt      = 0;
  bit           last_tie  = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  function automatic void acs_ref(input logic [W-1:0] pu, pl, bu, bl,
                                  output logic [W-1:0] win, output logic pk,
                                  output bit tie);
    logic [W-1:0] cu, cl, d;
    cu  = pu + bu;
    cl  = pl + bl;
    d   = cu - cl;
    pk  = d[W-1];
    win = pk ? cl : cu;
    tie = (cu == cl);
  endfunction

  // one cycle: drive at negedge, check, then advance the model over the posedge
  task automatic step(input logic s, input logic [3:0] b);
    bit in_word;
    int pos;
    logic [W-1:0] win;
    logic pk;
    bit tie;
    @(negedge clk);
    word_start_i = s;
    {metric_up_i, metric_lo_i, branch_up_i, branch_lo_i} = b;
    #1;
    in_word = s || mbusy;
    pos     = s ? 0 : mcnt;
    check(pick_valid_o == pend, "R5 valid pulse", pick_valid_o, pend);
    check(pick_lo_o == exp_pick, last_tie ? "R4 tie" : "R3 decision", pick_lo_o, exp_pick);
    check(metric_o == (in_word ? exp_store[pos] : 1'b0), "R2 R6 serial metric",
          metric_o, in_word ? exp_store[pos] : 1'b0);
    pend = 1'b0;
    if (in_word) begin
      acc_pu[pos] = b[3];
      acc_pl[pos] = b[2];
      acc_bu[pos] = b[1];
      acc_bl[pos] = b[0];
      if (pos == W - 1) begin
        acs_ref(acc_pu, acc_pl, acc_bu, acc_bl, win, pk, tie);
        exp_store = win;
        exp_pick  = pk;
        last_tie  = tie;
        pend      = 1'b1;
        mbusy     = 1'b0;
        mcnt      = 0;
      end else begin
        mbusy = 1'b1;
        mcnt  = pos + 1;
      end
    end
  endtask

  task automatic frame(input logic [W-1:0] pu, pl, bu, bl, input int len);
    for (int k = 0; k < len; k++)
      step(k == 0, {pu[k], pl[k], bu[k], bl[k]});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++)
      step(1'b0, 4'($urandom_range(15)));
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    #1;
    check(pick_valid_o == 1'b0, "R1 reset valid", pick_valid_o, 0);
    check(pick_lo_o == 1'b0, "R1 reset pick", pick_lo_o, 0);
    check(metric_o == 1'b0, "R1 reset metric", metric_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle(2);

    phase = "R1 first frame shows reset metric";
    frame(8'd10, 8'd20, 8'd3, 8'd1, W);
    phase = "R3 lower smaller";
    frame(8'd50, 8'd5, 8'd4, 8'd2, W);
    idle(1);
    phase = "R4 equal candidates";
    frame(8'd30, 8'd28, 8'd2, 8'd4, W);
    idle(1);
    phase = "R2 overflow wrap";
    frame(8'd250, 8'd100, 8'd10, 8'd20, W);
    phase = "R3 half-range straddle";
    frame(8'd0, 8'd128, 8'd0, 8'd1, W);
    frame(8'd0, 8'd127, 8'd0, 8'd1, W);
    phase = "R7 hold across idle";
    idle(5);
    frame(8'd1, 8'd1, 8'd1, 8'd1, W);
    phase = "R8 abort mid frame";
    frame(8'd200, 8'd0, 8'd0, 8'd0, 5);
    frame(8'd7, 8'd9, 8'd0, 8'd0, W);
    phase = "R9 idle garbage";
    idle(6);
    frame(8'd255, 8'd255, 8'd255, 8'd0, W);

    phase = "R10 random back-to-back";
    for (int n = 0; n < 400; n++) begin
      int len;
      len = ($urandom_range(9) == 0) ? int'($urandom_range(W - 1, 1)) : W;
      frame(8'($urandom), 8'($urandom), 8'($urandom_range(15)), 8'($urandom_range(15)), len);
      if ($urandom_range(2) == 0) idle($urandom_range(3, 1));
    end
    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog [%s] actual=1 expected=0", phase);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule